// File: doc/BRIEF.md
# Bidirectional Spike Counter with Sign Capture

This block reads out a current-to-frequency converter whose input current can flow either way. An upper-threshold comparator produces one spike stream, and a lower-threshold comparator produces the other. Each spike stands for a fixed packet of charge. The block counts spikes over a fixed sampling window, so the count gives the magnitude of the current. It also records which comparator fired first in the window, which gives the sign.

Both spike lines are asynchronous to the system clock. Each line is synchronized and edge-detected, and both feed a single magnitude counter. After reset and at the start of every window, the counter holds all ones, so the first spike takes it to zero.

A parameterized window timer closes each window. At that point the block does three things:
- It registers the closed window's result as one sample word.
- It raises a one-cycle valid strobe.
- It clears the counter and the direction bits for the next window.

Top module: `spike_readout`

## Requirements
- R1: Each rising edge on a spike input is counted exactly once.
  - The high time may be any length of one clock or more, provided the low time between spikes is at least two clocks.
  - A rising edge reaches the live count two clock edges after the edge that first samples the input high.
- R2: Spikes from both inputs add into one magnitude.
  - Rising edges that arrive on both inputs in the same cycle add two.
- R3: The first spike of a window sets the direction bit of its input: `dirUp` for the upper input, `dirDn` for the lower input.
  - The other bit stays clear for the rest of that window, even after later spikes on the other input.
  - If the first spikes on the two inputs arrive in the same cycle, the upper input wins.
- R4: The live count output sits at all ones after reset and at the start of every window.
  - The first spike takes it to zero.
  - Each further spike adds one, so the spike total equals the live count plus one.
- R5: A window with no spike reports magnitude zero with both direction bits clear. The all-ones counter state means zero spikes.
- R6: The magnitude saturates at 2^CNT_W − 1 spikes; it does not wrap. Once saturated, the live count stays at 2^CNT_W − 2.
- R7: Every WIN_CYCLES clocks, `sampleValid` pulses high for one cycle and `sampleWord` takes the closed window's result. The sample word is laid out as:
  - bit CNT_W+1: the upper direction bit
  - bit CNT_W: the lower direction bit
  - bits CNT_W−1..0: the spike total
- R8: Spikes whose rising edge reaches the counter in the closing cycle belong to the new window. A spike one cycle earlier belongs to the closing window.
- R9: While `rstN` is low, the outputs hold these values:
  - live count: all ones
  - direction bits: clear
  - `sampleValid`: low
  - `sampleWord`: zero

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upSpikeIn | input | 1 | Spike line from the upper-threshold comparator, asynchronous |
| dnSpikeIn | input | 1 | Spike line from the lower-threshold comparator, asynchronous |
| dirUp | output | 1 | Live flag: the first spike of this window came from the upper input |
| dirDn | output | 1 | Live flag: the first spike of this window came from the lower input |
| liveCount | output | CNT_W | Raw counter; all ones means no spike yet |
| sampleWord | output | CNT_W+2 | Result of the last closed window: {dirUp, dirDn, magnitude} |
| sampleValid | output | 1 | One-cycle strobe when sampleWord updates |

## Verification
The assertions assume that a spike line stays low for at least two clocks between pulses. Under that assumption, each synchronized edge appears as a single-cycle pulse. The assertions also assume that the window is at least two cycles long, so the valid strobe can never stay high on consecutive cycles.

The stimulus drives every pulse with a high time of one to three clocks followed by three low clocks. It sends each window's spikes well inside the window, except in the two boundary cases, which are timed to the cycle. The sweep covers every spike count from zero to past saturation in both directions. It also covers sign reversal within a window and simultaneous first spikes.

// File: rtl/spike_readout_pkg.sv
package spike_readout_pkg;

  // Strobes from the window controller to the datapath.
  typedef struct packed {
    logic clearWin;    // counter and direction bits restart with this cycle's edges
    logic loadSample;  // register the closing window's result
  } winStrobes_t;

  localparam int NUM_LANES = 2;
  localparam int LANE_UP   = 0;
  localparam int LANE_DN   = 1;

endpackage

// File: rtl/spike_edge_sync.sv
module spike_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic rise
);
  localparam int LAST = STAGES;

  // stages 0..STAGES-1 synchronize, stage STAGES holds the previous value
  logic [LAST:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[LAST-1:0], rawIn};
  end

  assign rise = chain[LAST-1] & ~chain[LAST];

  // R1: a synchronized edge is a single-cycle pulse
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise);

endmodule

// File: rtl/window_ctrl.sv
module window_ctrl
  import spike_readout_pkg::*;
#(
  parameter int WIN_CYCLES = 125000
) (
  input  logic        clk,
  input  logic        rstN,
  output winStrobes_t strobes
);
  localparam int TW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(WIN_CYCLES - 1);

  logic [TW-1:0] tick;
  logic          atEnd;

  assign atEnd = (tick == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      tick <= '0;
    else if (atEnd) tick <= '0;
    else            tick <= tick + 1'b1;
  end

  always_comb begin
    strobes.clearWin   = atEnd;
    strobes.loadSample = atEnd;
  end

  // R7: the timer wraps to zero after the last tick
  p_window_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    atEnd |=> (tick == '0));

  // R7: the timer never passes the last tick
  p_tick_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    tick <= LAST_TICK);

endmodule

// File: rtl/spike_datapath.sv
module spike_datapath
  import spike_readout_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               upRise,
  input  logic               dnRise,
  input  winStrobes_t        strobes,
  output logic               dirUp,
  output logic               dirDn,
  output logic [CNT_W-1:0]   rawCount,
  output logic [CNT_W+1:0]   sampleWord,
  output logic               sampleValid
);
  localparam int MW = CNT_W + 1;
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [MW-1:0]    MAX_MAG  = MW'((64'd1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] SAT_RAW  = CNT_W'((64'd1 << CNT_W) - 2);

  logic [1:0]       incCount;
  logic [CNT_W-1:0] baseRaw;
  logic             baseUp, baseDn;
  logic [MW-1:0]    curMag, baseMag, sumMag, newMag;
  logic [CNT_W-1:0] nextRaw;
  logic             nextUp, nextDn;

  assign incCount = {1'b0, upRise} + {1'b0, dnRise};

  // spike total of the window now closing or running
  assign curMag = (rawCount == ALL_ONES) ? '0 : ({1'b0, rawCount} + 1'b1);

  always_comb begin
    baseRaw = strobes.clearWin ? ALL_ONES : rawCount;
    baseUp  = strobes.clearWin ? 1'b0 : dirUp;
    baseDn  = strobes.clearWin ? 1'b0 : dirDn;
    baseMag = (baseRaw == ALL_ONES) ? '0 : ({1'b0, baseRaw} + 1'b1);
    sumMag  = baseMag + MW'(incCount);
    newMag  = (sumMag > MAX_MAG) ? MAX_MAG : sumMag;
    nextRaw = (newMag == '0) ? ALL_ONES : CNT_W'(newMag - 1'b1);
    // first spike wins; the upper input has priority on a tie
    nextUp  = baseUp | (upRise & ~baseDn);
    nextDn  = baseDn | (dnRise & ~baseUp & ~upRise);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawCount <= ALL_ONES;
      dirUp    <= 1'b0;
      dirDn    <= 1'b0;
    end else begin
      rawCount <= nextRaw;
      dirUp    <= nextUp;
      dirDn    <= nextDn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleWord  <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobes.loadSample;
      if (strobes.loadSample)
        sampleWord <= {dirUp, dirDn, curMag[CNT_W-1:0]};
    end
  end

  // R3: the two direction bits never both hold
  p_dir_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(dirUp && dirDn));

  // R3: a set direction bit holds until the window closes
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dirUp && !strobes.clearWin) |=> dirUp);

  // R6: the saturated count stays put inside a window
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rawCount == SAT_RAW && !strobes.clearWin) |=> (rawCount == SAT_RAW));

  // R2: inside a window the count only moves upward, from its first spike on
  p_count_rises_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rawCount != ALL_ONES && !strobes.clearWin) |=> (rawCount >= $past(rawCount)));

  // R4: a window closing with no new edge restarts at all ones
  p_restart_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearWin && !upRise && !dnRise) |=> (rawCount == ALL_ONES && !dirUp && !dirDn));

  // R7: the valid strobe lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

endmodule

// File: rtl/spike_readout.sv
module spike_readout
  import spike_readout_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int WIN_CYCLES  = 125000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             upSpikeIn,
  input  logic             dnSpikeIn,
  output logic             dirUp,
  output logic             dirDn,
  output logic [CNT_W-1:0] liveCount,
  output logic [CNT_W+1:0] sampleWord,
  output logic             sampleValid
);
  logic [NUM_LANES-1:0] laneIn;
  logic [NUM_LANES-1:0] laneRise;
  winStrobes_t          strobes;

  assign laneIn[LANE_UP] = upSpikeIn;
  assign laneIn[LANE_DN] = dnSpikeIn;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    spike_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (laneIn[g]),
      .rise  (laneRise[g])
    );
  end

  window_ctrl #(.WIN_CYCLES(WIN_CYCLES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes)
  );

  spike_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .upRise      (laneRise[LANE_UP]),
    .dnRise      (laneRise[LANE_DN]),
    .strobes     (strobes),
    .dirUp       (dirUp),
    .dirDn       (dirDn),
    .rawCount    (liveCount),
    .sampleWord  (sampleWord),
    .sampleValid (sampleValid)
  );

endmodule

// File: tb/spike_readout_tb.sv
module spike_readout_tb_top;
  localparam int CNT_W = 6;
  localparam int WIN   = 500;
  localparam int MAXM  = (1 << CNT_W) - 1;
  localparam int ONES  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upSpikeIn = 1'b0;
  logic dnSpikeIn = 1'b0;
  logic dirUp, dirDn, sampleValid;
  logic [CNT_W-1:0] liveCount;
  logic [CNT_W+1:0] sampleWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  spike_readout #(.CNT_W(CNT_W), .WIN_CYCLES(WIN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .upSpikeIn(upSpikeIn), .dnSpikeIn(dnSpikeIn),
    .dirUp(dirUp), .dirDn(dirDn), .liveCount(liveCount),
    .sampleWord(sampleWord), .sampleValid(sampleValid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit up, input bit dn, input int width);
    if (up) upSpikeIn = 1'b1;
    if (dn) dnSpikeIn = 1'b1;
    repeat (width) @(negedge clk);
    upSpikeIn = 1'b0;
    dnSpikeIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic waitValid(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sampleValid && n < 3 * WIN);
    chk(sampleValid == 1'b1, "R7 valid strobe seen", int'(sampleValid), 1);
  endtask

  task automatic checkSample(input bit eu, input bit ed, input int em, input string tag);
    chk(sampleWord[CNT_W+1] == eu, {tag, " sample up bit"}, int'(sampleWord[CNT_W+1]), int'(eu));
    chk(sampleWord[CNT_W]   == ed, {tag, " sample down bit"}, int'(sampleWord[CNT_W]), int'(ed));
    chk(int'(sampleWord[CNT_W-1:0]) == em, {tag, " sample magnitude"},
        int'(sampleWord[CNT_W-1:0]), em);
  endtask

  // nA spikes on the first input, then nB on the other; optional leading tie
  task automatic sendWindow(input int nA, input int nB, input bit aIsUp, input bit tie);
    int tot, mag, expRaw, n;
    bit eu, ed;
    tot = nA + nB + (tie ? 2 : 0);
    mag = (tot > MAXM) ? MAXM : tot;
    expRaw = (mag == 0) ? ONES : mag - 1;
    if (tie)         begin eu = 1; ed = 0; end
    else if (nA > 0) begin eu = aIsUp; ed = !aIsUp; end
    else if (nB > 0) begin eu = !aIsUp; ed = aIsUp; end
    else             begin eu = 0; ed = 0; end
    if (tie) pulse(1'b1, 1'b1, 1);
    for (int k = 0; k < nA; k++) pulse(aIsUp, !aIsUp, 1 + (k % 3));
    for (int k = 0; k < nB; k++) pulse(!aIsUp, aIsUp, 1 + (k % 3));
    @(negedge clk);
    // R1 R4 R6: live count equals total minus one, clamped
    chk(int'(liveCount) == expRaw, "R4 live count", int'(liveCount), expRaw);
    // R3: live direction bits
    chk(dirUp == eu && dirDn == ed, "R3 live direction", int'({dirUp, dirDn}), int'({eu, ed}));
    waitValid(n);
    checkSample(eu, ed, mag, "R2 R5 R6");
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(int'(liveCount) == ONES, "R9 reset count", int'(liveCount), ONES);
    chk(!dirUp && !dirDn, "R9 reset direction", int'({dirUp, dirDn}), 0);
    chk(!sampleValid, "R9 reset valid", int'(sampleValid), 0);
    chk(sampleWord == '0, "R9 reset sample", int'(sampleWord), 0);
    rstN = 1'b1;

    waitValid(n);
    checkSample(0, 0, 0, "R5 first empty");
    waitValid(n);
    // R7: window period
    chk(n == WIN, "R7 window period", n, WIN);

    // R5 R6 R2: sweep counts through saturation, both signs
    for (int c = 0; c <= MAXM + 3; c++) sendWindow(c, 0, 1'b1, 1'b0);
    for (int c = 1; c <= MAXM + 3; c++) sendWindow(c, 0, 1'b0, 1'b0);
    // R3: reversal inside a window keeps the first sign
    sendWindow(3, 7, 1'b1, 1'b0);
    sendWindow(2, 9, 1'b0, 1'b0);
    sendWindow(1, 40, 1'b0, 1'b0);
    // R2 R3: simultaneous first spikes count two, upper wins
    sendWindow(0, 0, 1'b1, 1'b1);
    sendWindow(4, 5, 1'b0, 1'b1);

    // R8: spike counted one cycle before closing stays in the old window
    fork
      begin repeat (WIN - 4) @(negedge clk); pulse(1'b0, 1'b1, 2); end
    join_none
    waitValid(n);
    checkSample(0, 1, 1, "R8 early edge");
    // R8: spike counted in the closing cycle moves to the new window
    fork
      begin repeat (WIN - 3) @(negedge clk); pulse(1'b1, 1'b0, 2); end
    join_none
    waitValid(n);
    checkSample(0, 0, 0, "R8 boundary old window");
    waitValid(n);
    checkSample(1, 0, 1, "R8 boundary new window");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule